// File: doc/BRIEF.md
# Bus Error and Timeout Monitor

This block sits beside a processor's local bus and its system-bus requester and decides when a pending cycle must be ended with a bus error. It watches four sources: a local cycle that is never acknowledged, a system-bus request that waits too long for a grant, an external bus-error line asserted while this board owns the system bus, and a DRAM parity failure. Each accepted error produces a single-cycle `bus_err` pulse and sets one sticky status flag.

Two watchdogs with separately programmed limits count the local-completion wait and the grant wait. A parity failure seen while the network controller owns the local bus is reported by withholding that controller's ready (`net_nrdy`) instead of a bus error. Only the CPU as parity-time master records the parity flag. Software programs the limits and the parity mode and clears flags through a small write port.

Top module: `buserr_monitor`

## Requirements
- R1: After reset `bus_err` and `net_nrdy` are 0, all four flags in `err_status` are 0, both limits are 0 and parity checking is off.
- R2: A local cycle (`lcl_strobe` high, `lcl_sysrange` low) with limit T>0 that sees no `lcl_ack` in its first T sampled cycles gives `bus_err`=1 in the cycle after the (T+1)th sampled edge and sets `err_status[0]`; an ack sampled on or before that edge prevents it, and strobes with `lcl_sysrange` high are never timed.
- R3: A system-bus request (`sys_req` high) with grant limit T>0 that sees no `sys_grant` for T+1 sampled edges gives one `bus_err` pulse and sets `err_status[1]`.
- R4: A limit of 0 disables its watchdog.
- R5: `ext_berr` sampled high while `sys_grant` is high gives `bus_err` on the next cycle and sets `err_status[2]`; with `sys_grant` low it is ignored; a line held high reports once until the line or the grant drops.
- R6: Parity mode is written at register address 2 (bits 1:0); values 2 and 3 enable checking, 0 and 1 ignore `par_err`. With checking on, `par_err` with master code 0 (CPU) or 1 (peripheral controller) gives `bus_err`; only code 0 sets `err_status[3]`.
- R7: With checking on, `par_err` with master code 2 (network controller) gives a one-cycle `net_nrdy` pulse and neither `bus_err` nor a flag.
- R8: Flags are sticky and cleared by writing 1s to register address 3 (bit i clears flag i); a flag set by an error in the same cycle as its clear stays set.
- R9: When sources fire in the same cycle the order is external error, then parity, then local timeout, then grant timeout; only the winner's flag is set and `bus_err` pulses once.
- R10: Any `bus_err` ends both pending timed cycles: neither watchdog fires again until its qualifying condition drops.
- R11: A timed-out cycle that stays asserted raises `bus_err` only once.
- R12: Register address 0 holds the local limit and address 1 the grant limit, taking effect on the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lcl_strobe | input | 1 | Local-bus cycle in progress |
| lcl_ack | input | 1 | Local-bus cycle acknowledge |
| lcl_sysrange | input | 1 | Current address decodes to the system-bus range |
| sys_req | input | 1 | System-bus request pending |
| sys_grant | input | 1 | System-bus granted; this board is master |
| ext_berr | input | 1 | External bus-error line |
| par_err | input | 1 | DRAM parity failure on this cycle |
| par_master | input | 2 | Local master: 0 CPU, 1 peripheral controller, 2 network controller |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | TW | Register write data |
| bus_err | output | 1 | One-cycle bus-error pulse |
| net_nrdy | output | 1 | One-cycle ready-withhold to the network controller |
| err_status | output | 4 | Sticky flags: 0 local timeout, 1 grant timeout, 2 external error, 3 parity |

## Verification
The bench sweeps each limit over small values and moves the acknowledge across every cycle up to the firing edge, so an off-by-one watchdog shows as a pulse one cycle early or late, and an ack that loses to the timeout on the final edge shows as a spurious error. It crosses all parity modes with all master codes, where a design that let the network master or peripheral controller set the parity flag, or treated mode 1 as enabled, gets a wrong flag. Simultaneous sources catch a wrong precedence order or a second flag slipping through, and a held external line or held strobe catches repeated pulses. A clear written in the same cycle as a new error catches a design that lets clearing win.

// File: rtl/buserr_pkg.sv
package buserr_pkg;

    localparam int ST_LBTO = 0;
    localparam int ST_VATO = 1;
    localparam int ST_BERR = 2;
    localparam int ST_PE   = 3;
    localparam int ST_W    = 4;

    typedef enum logic [1:0] {
        MST_CPU    = 2'd0,
        MST_PERIPH = 2'd1,
        MST_NET    = 2'd2,
        MST_OTHER  = 2'd3
    } master_e;

    typedef enum logic [1:0] {
        RA_LCL_LIM  = 2'd0,
        RA_GNT_LIM  = 2'd1,
        RA_PAR_MODE = 2'd2,
        RA_CLEAR    = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic berr;
        logic parity;
        logic lcl_to;
        logic gnt_to;
    } err_ev_t;

    function automatic logic parity_enabled(input logic [1:0] mode);
        return mode[1];
    endfunction

    function automatic err_ev_t pick_winner(input err_ev_t ev);
        err_ev_t w;
        w = '0;
        if (ev.berr)        w.berr   = 1'b1;
        else if (ev.parity) w.parity = 1'b1;
        else if (ev.lcl_to) w.lcl_to = 1'b1;
        else if (ev.gnt_to) w.gnt_to = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/buserr_wdog.sv
module buserr_wdog #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  logic          complete,
    input  logic          abort,
    input  logic [TW-1:0] limit,
    output logic          fire
);
    logic [TW-1:0] cnt;
    logic          spent;
    logic          counting;

    assign counting = active && !complete && !spent;
    assign fire     = counting && (limit != '0) && (cnt >= limit);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cnt   <= '0;
            spent <= 1'b0;
        end else if (complete) begin
            cnt   <= '0;
        end else if (fire || abort) begin
            spent <= 1'b1;
        end else if (counting && cnt != {TW{1'b1}}) begin
            cnt   <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/buserr_cfg.sv
module buserr_cfg
    import buserr_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_we,
    input  logic [1:0]      reg_addr,
    input  logic [TW-1:0]   reg_wdata,
    output logic [TW-1:0]   lcl_lim,
    output logic [TW-1:0]   gnt_lim,
    output logic [1:0]      par_mode,
    output logic [ST_W-1:0] clr_mask
);
    reg_addr_e ra;
    assign ra = reg_addr_e'(reg_addr);

    assign clr_mask = (reg_we && ra == RA_CLEAR) ? reg_wdata[ST_W-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            lcl_lim  <= '0;
            gnt_lim  <= '0;
            par_mode <= 2'd0;
        end else if (reg_we) begin
            case (ra)
                RA_LCL_LIM:  lcl_lim  <= reg_wdata;
                RA_GNT_LIM:  gnt_lim  <= reg_wdata;
                RA_PAR_MODE: par_mode <= reg_wdata[1:0];
                default:     ;
            endcase
        end
    end
endmodule

// File: rtl/buserr_monitor.sv
module buserr_monitor
    import buserr_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            lcl_strobe,
    input  logic            lcl_ack,
    input  logic            lcl_sysrange,
    input  logic            sys_req,
    input  logic            sys_grant,
    input  logic            ext_berr,
    input  logic            par_err,
    input  logic [1:0]      par_master,
    input  logic            reg_we,
    input  logic [1:0]      reg_addr,
    input  logic [TW-1:0]   reg_wdata,
    output logic            bus_err,
    output logic            net_nrdy,
    output logic [ST_W-1:0] err_status
);
    logic [TW-1:0]   lcl_lim, gnt_lim;
    logic [1:0]      par_mode;
    logic [ST_W-1:0] clr_mask, set_mask;
    logic            lcl_fire, gnt_fire, abort, berr_seen, chk_on;
    master_e         mst;
    err_ev_t         ev, win;

    buserr_cfg #(.TW(TW)) u_cfg (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .lcl_lim(lcl_lim), .gnt_lim(gnt_lim),
        .par_mode(par_mode), .clr_mask(clr_mask)
    );

    buserr_wdog #(.TW(TW)) u_lcl_wdog (
        .clk(clk), .rst(rst), .active(lcl_strobe && !lcl_sysrange),
        .complete(lcl_ack), .abort(abort), .limit(lcl_lim), .fire(lcl_fire)
    );

    buserr_wdog #(.TW(TW)) u_gnt_wdog (
        .clk(clk), .rst(rst), .active(sys_req),
        .complete(sys_grant), .abort(abort), .limit(gnt_lim), .fire(gnt_fire)
    );

    assign mst    = master_e'(par_master);
    assign chk_on = parity_enabled(par_mode);

    always_comb begin
        ev.berr   = ext_berr && sys_grant && !berr_seen;
        ev.parity = par_err && chk_on && (mst != MST_NET);
        ev.lcl_to = lcl_fire;
        ev.gnt_to = gnt_fire;
        win       = pick_winner(ev);
        abort     = |win;
        set_mask          = '0;
        set_mask[ST_LBTO] = win.lcl_to;
        set_mask[ST_VATO] = win.gnt_to;
        set_mask[ST_BERR] = win.berr;
        set_mask[ST_PE]   = win.parity && (mst == MST_CPU);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_err    <= 1'b0;
            net_nrdy   <= 1'b0;
            err_status <= '0;
            berr_seen  <= 1'b0;
        end else begin
            bus_err    <= abort;
            net_nrdy   <= par_err && chk_on && (mst == MST_NET);
            err_status <= (err_status & ~clr_mask) | set_mask;
            if (!(ext_berr && sys_grant)) berr_seen <= 1'b0;
            else if (ev.berr)             berr_seen <= 1'b1;
        end
    end
endmodule

// File: rtl/buserr_monitor_chk.sv
module buserr_monitor_chk #(
    parameter int TW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          reg_we,
    input logic [1:0]    reg_addr,
    input logic [TW-1:0] reg_wdata,
    input logic          ext_berr,
    input logic          sys_grant,
    input logic          par_err,
    input logic [1:0]    par_master,
    input logic          bus_err,
    input logic          net_nrdy,
    input logic [3:0]    err_status
);
    for (genvar i = 0; i < 4; i++) begin : g_sticky
        assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
            ($past(err_status[i]) &&
             !($past(reg_we) && $past(reg_addr) == 2'd3 && $past(reg_wdata[i])))
            |-> err_status[i]);
    end

    assert_one_flag_R9: assert property (@(posedge clk) disable iff (rst)
        $countones(err_status & ~$past(err_status)) <= 1);

    assert_flag_with_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        (err_status != $past(err_status) && (err_status & ~$past(err_status)) != 4'd0)
        |-> bus_err);

    assert_pe_cpu_only_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(err_status[3]) |-> $past(par_err && par_master == 2'd0));

    assert_berr_master_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(err_status[2]) |-> $past(ext_berr && sys_grant));

    assert_nrdy_net_R7: assert property (@(posedge clk) disable iff (rst)
        net_nrdy |-> $past(par_err && par_master == 2'd2));
endmodule

bind buserr_monitor buserr_monitor_chk #(.TW(TW)) u_chk (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .ext_berr(ext_berr), .sys_grant(sys_grant),
    .par_err(par_err), .par_master(par_master), .bus_err(bus_err),
    .net_nrdy(net_nrdy), .err_status(err_status)
);

// File: tb/buserr_monitor_tb.sv
module buserr_monitor_tb;
    localparam int TW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lcl_strobe = 0, lcl_ack = 0, lcl_sysrange = 0;
    logic sys_req = 0, sys_grant = 0, ext_berr = 0, par_err = 0;
    logic [1:0] par_master = 0;
    logic reg_we = 0;
    logic [1:0] reg_addr = 0;
    logic [TW-1:0] reg_wdata = 0;
    logic bus_err, net_nrdy;
    logic [3:0] err_status;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    buserr_monitor #(.TW(TW)) u_dut (
        .clk(clk), .rst(rst), .lcl_strobe(lcl_strobe), .lcl_ack(lcl_ack),
        .lcl_sysrange(lcl_sysrange), .sys_req(sys_req), .sys_grant(sys_grant),
        .ext_berr(ext_berr), .par_err(par_err), .par_master(par_master),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .bus_err(bus_err), .net_nrdy(net_nrdy), .err_status(err_status)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        reg_we = 1; reg_addr = 2'(a); reg_wdata = TW'(d);
        step();
        reg_we = 0;
    endtask

    task automatic expect_out(input string req, input int be, input int nr, input int st);
        chk(bus_err == 1'(be), req, bus_err, be);
        chk(net_nrdy == 1'(nr), req, net_nrdy, nr);
        chk(err_status == 4'(st), req, err_status, st);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step(); step();
        rst = 0;
        // R1 reset state
        expect_out("R1", 0, 0, 0);

        // R2 R11 R12 local timeout cycle exact timing
        for (int t = 1; t <= 5; t++) begin
            wr(0, t);
            lcl_strobe = 1;
            for (int i = 0; i < t; i++) begin
                step();
                chk(bus_err == 0, "R2 early", bus_err, 0);
            end
            step();
            expect_out("R2", 1, 0, 1);
            step(); step();
            chk(bus_err == 0, "R11 single pulse", bus_err, 0);
            lcl_strobe = 0;
            step();
            wr(3, 1);
            chk(err_status == 0, "R8 clear", err_status, 0);
        end

        // R2 ack at every cycle up to the firing edge
        for (int t = 1; t <= 4; t++) begin
            wr(0, t);
            for (int a = 0; a <= t; a++) begin
                lcl_strobe = 1;
                repeat (a) step();
                lcl_ack = 1;
                step();
                lcl_ack = 0; lcl_strobe = 0;
                step();
                chk(bus_err == 0 && err_status == 0, "R2 ack in time", err_status, 0);
            end
        end

        // R2 system-range strobe never timed
        wr(0, 2);
        lcl_strobe = 1; lcl_sysrange = 1;
        repeat (10) begin
            step();
            chk(bus_err == 0 && err_status == 0, "R2 sysrange ignored", err_status, 0);
        end
        lcl_strobe = 0; lcl_sysrange = 0;

        // R4 zero limits disable
        wr(0, 0); wr(1, 0);
        lcl_strobe = 1; sys_req = 1;
        repeat (40) step();
        expect_out("R4", 0, 0, 0);
        lcl_strobe = 0; sys_req = 0;
        step();

        // R3 grant timeout
        for (int t = 1; t <= 4; t++) begin
            wr(1, t);
            sys_req = 1;
            for (int i = 0; i < t; i++) begin
                step();
                chk(bus_err == 0, "R3 early", bus_err, 0);
            end
            step();
            expect_out("R3", 1, 0, 2);
            step();
            chk(bus_err == 0, "R3 single pulse", bus_err, 0);
            sys_req = 0;
            step();
            wr(3, 15);
        end
        // R3 grant in time
        wr(1, 3);
        sys_req = 1;
        repeat (3) step();
        sys_grant = 1;
        repeat (6) step();
        chk(bus_err == 0 && err_status == 0, "R3 granted", err_status, 0);
        sys_req = 0; sys_grant = 0;
        wr(1, 0);

        // R5 external error
        ext_berr = 1;
        step();
        expect_out("R5 no master", 0, 0, 0);
        sys_grant = 1;
        step();
        expect_out("R5", 1, 0, 4);
        step(); step();
        chk(bus_err == 0, "R5 held once", bus_err, 0);
        ext_berr = 0;
        step();
        wr(3, 4);
        chk(err_status == 0, "R8 clear berr", err_status, 0);

        // R8 error in the same cycle as its clear stays set
        ext_berr = 1;
        reg_we = 1; reg_addr = 2'd3; reg_wdata = TW'(4);
        step();
        reg_we = 0; ext_berr = 0;
        chk(err_status == 4, "R8 set wins", err_status, 4);
        wr(3, 4);
        chk(err_status == 0, "R8 clear after", err_status, 0);
        sys_grant = 0;

        // R6 R7 parity: every mode by every master
        for (int m = 0; m < 4; m++) begin
            wr(2, m);
            for (int ms = 0; ms < 3; ms++) begin
                par_err = 1; par_master = 2'(ms);
                step();
                par_err = 0;
                if (ms == 2)
                    expect_out("R7", 0, (m >= 2) ? 1 : 0, 0);
                else
                    expect_out("R6", (m >= 2) ? 1 : 0, 0,
                               (m >= 2 && ms == 0) ? 8 : 0);
                wr(3, 15);
            end
        end
        par_master = 0;

        // R9 R10 local vs grant timeouts together
        wr(0, 3); wr(1, 3);
        lcl_strobe = 1; sys_req = 1;
        repeat (3) step();
        step();
        expect_out("R9 local over grant", 1, 0, 1);
        repeat (4) begin
            step();
            expect_out("R10 grant aborted", 0, 0, 1);
        end
        lcl_strobe = 0; sys_req = 0;
        step();
        wr(3, 15);

        // R9 external over parity
        wr(2, 3);
        sys_grant = 1; ext_berr = 1; par_err = 1; par_master = 0;
        step();
        par_err = 0; ext_berr = 0; sys_grant = 0;
        expect_out("R9 berr over parity", 1, 0, 4);
        step();
        chk(bus_err == 0, "R9 one pulse", bus_err, 0);
        wr(3, 15);

        // R9 R10 parity over local timeout
        wr(0, 2);
        lcl_strobe = 1;
        repeat (2) step();
        par_err = 1;
        step();
        par_err = 0;
        expect_out("R9 parity over timeout", 1, 0, 8);
        repeat (3) begin
            step();
            expect_out("R10 local aborted", 0, 0, 8);
        end
        lcl_strobe = 0;
        step();
        wr(3, 15);
        chk(err_status == 0, "R8 final clear", err_status, 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule